// File: doc/BRIEF.md
# Transmit FIFO Interrupt Controller

This block is a four-slot byte queue between a host that writes transmit bytes and a serializer that loads them one at a time. The host writes into the entry slot. Each byte moves one slot per clock toward the exit slot, as long as the slot ahead of it is free. The serializer sees a load request while the exit slot holds a byte, and takes that byte with a one-cycle acknowledge. The block reports a buffer-empty status, which means the entry slot is free, so the host may poll it as a "room for one more byte" indication.

The block also keeps an interrupt-pending flag, which a configurable policy raises. With the policy bit at 1 (its value after reset), the flag rises only when the serializer takes the last byte and the queue is left with nothing in it. With the policy bit at 0, the flag rises every time the entry slot frees up, so the host gets one interrupt per byte until the queue is full. An end-of-frame event from the serializer also raises the flag. A data write or an explicit clear command lowers it, and a raising event in the same clock wins over the clear. The interrupt line is the pending flag gated by an enable input. The flag keeps tracking events while the enable is low.

Top module: `txfifo_irq_ctrl`

## Requirements
- R1: After reset the queue is empty, `ld_req`=0, `buf_empty`=1, `pend`=0, `irq`=0, `overflow`=0, and the policy bit is 1 (drain-empty policy).
- R2: Bytes leave through `ld_data` in the order they were written. A byte written into an empty queue raises `ld_req` on the third rising edge after its write edge. `ld_data` holds steady while `ld_req` is high and `ld_ack` is low.
- R3: A `host_wr` while the entry slot is occupied is dropped without changing the queue contents, and `overflow` goes to 1 and stays 1 until reset.
- R4: `buf_empty` is 1 exactly when the entry slot is free, in either policy and whatever the state of `pend`. An accepted write makes it 0 on the next edge.
- R5: With the policy bit at 1, `pend` rises on the edge where an acknowledged load removes the only byte in the queue. It does not rise while other bytes remain, and it does not rise when the entry slot frees.
- R6: With the policy bit at 0, `pend` rises on the edge where a byte leaves the entry slot, which is one clock after the write when the next slot is free.
- R7: `pend` is cleared by any `host_wr` (accepted or dropped) or by `clr_pend`, when no raising event occurs in that clock.
- R8: When a raising event and a clear (`clr_pend` or `host_wr`) occur in the same clock, `pend` ends up 1.
- R9: A pulse on `eof_evt` raises `pend` on the next edge under either policy.
- R10: `irq` is 1 only when both `pend` and `irq_en` are 1. `pend` follows events while `irq_en` is 0, and raising `irq_en` alone never sets `pend`.
- R11: A `cfg_wr` pulse loads `cfg_mode` into the policy bit (1 = drain-empty, 0 = every freed entry slot).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host byte write strobe |
| host_data | input | DW | Host byte |
| cfg_wr | input | 1 | Load strobe for the policy bit |
| cfg_mode | input | 1 | Policy value: 1 = drain-empty, 0 = every freed entry slot |
| irq_en | input | 1 | Interrupt enable |
| clr_pend | input | 1 | Clear-pending command strobe |
| ld_req | output | 1 | Exit slot holds a byte for the serializer |
| ld_data | output | DW | Byte in the exit slot |
| ld_ack | input | 1 | Serializer takes the exit byte this clock |
| eof_evt | input | 1 | Serializer end-of-frame event |
| buf_empty | output | 1 | Entry slot is free |
| pend | output | 1 | Interrupt-pending flag |
| irq | output | 1 | Gated interrupt request |
| overflow | output | 1 | Sticky dropped-write indication |

## Verification
The properties assume that the serializer pulses `ld_ack` only while `ld_req` is high. They also assume that `eof_evt` arrives only when the queue holds no bytes, because the end of a frame follows the last byte being loaded. The stimulus raises the acknowledge only after seeing `ld_req` at a falling edge. It fires the end-of-frame pulse only after draining every byte. Apart from one deliberate collision that exercises the overflow path, it writes only when `buf_empty` reads 1.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic {
    MODE_EACH_SLOT = 1'b0,
    MODE_ALL_EMPTY = 1'b1
  } txq_mode_e;
endpackage

// File: rtl/txq_slots.sv
module txq_slots #(
  parameter int DEPTH = 4,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          pop,
  output logic          head_valid,
  output logic [DW-1:0] head_data,
  output logic          entry_busy,
  output logic          entry_vacate,
  output logic          drained
);
  localparam int ENTRY = DEPTH - 1;
  localparam logic [DEPTH-1:0] ONLY_HEAD = {{(DEPTH-1){1'b0}}, 1'b1};

  logic [DEPTH-1:0] vld_q, vld_d;
  logic [DEPTH-1:0] free_s, mv_in, leave;
  logic [DW-1:0]    dat_q [DEPTH];
  logic [DW-1:0]    dat_d [DEPTH];
  logic             pop_ok, accept;

  assign pop_ok = pop & vld_q[0];
  assign accept = wr_en & ~vld_q[ENTRY];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == 0) begin : g_head
      assign free_s[i] = ~vld_q[i] | pop_ok;
      assign leave[i]  = pop_ok;
    end else begin : g_body
      assign free_s[i] = ~vld_q[i];
      assign leave[i]  = mv_in[i-1];
    end
    if (i == ENTRY) begin : g_entry
      assign mv_in[i] = accept;
      assign dat_d[i] = wr_data;
    end else begin : g_inner
      assign mv_in[i] = vld_q[i+1] & free_s[i];
      assign dat_d[i] = dat_q[i+1];
    end
    assign vld_d[i] = (vld_q[i] & ~leave[i]) | mv_in[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (mv_in[i]) dat_q[i] <= dat_d[i];
    end
  end

  assign head_valid   = vld_q[0];
  assign head_data    = dat_q[0];
  assign entry_busy   = vld_q[ENTRY];
  assign entry_vacate = leave[ENTRY];
  assign drained      = pop_ok & (vld_q == ONLY_HEAD) & ~accept;
endmodule

// File: rtl/txq_pend.sv
module txq_pend
  import txq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic cfg_mode,
  input  logic entry_vacate,
  input  logic drained,
  input  logic eof_evt,
  input  logic host_wr,
  input  logic clr_pend,
  output logic pend,
  output logic mode_all_empty
);
  txq_mode_e mode_q, mode_d;
  logic      pend_q, pend_d;
  logic      set_evt, clr_evt;

  always_comb begin
    mode_d = mode_q;
    if (cfg_wr) mode_d = cfg_mode ? MODE_ALL_EMPTY : MODE_EACH_SLOT;
  end

  always_comb begin
    set_evt = eof_evt | ((mode_q == MODE_ALL_EMPTY) ? drained : entry_vacate);
    clr_evt = host_wr | clr_pend;
    if (set_evt)      pend_d = 1'b1;
    else if (clr_evt) pend_d = 1'b0;
    else              pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_ALL_EMPTY;
      pend_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      pend_q <= pend_d;
    end
  end

  assign pend           = pend_q;
  assign mode_all_empty = (mode_q == MODE_ALL_EMPTY);
endmodule

// File: rtl/txfifo_irq_ctrl.sv
module txfifo_irq_ctrl #(
  parameter int DEPTH = 4,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [DW-1:0] host_data,
  input  logic          cfg_wr,
  input  logic          cfg_mode,
  input  logic          irq_en,
  input  logic          clr_pend,
  output logic          ld_req,
  output logic [DW-1:0] ld_data,
  input  logic          ld_ack,
  input  logic          eof_evt,
  output logic          buf_empty,
  output logic          pend,
  output logic          irq,
  output logic          overflow
);
  logic entry_busy, entry_vacate, drained, mode_all_empty;
  logic ovf_q, ovf_d;

  txq_slots #(.DEPTH(DEPTH), .DW(DW)) u_slots (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (host_wr),
    .wr_data      (host_data),
    .pop          (ld_ack),
    .head_valid   (ld_req),
    .head_data    (ld_data),
    .entry_busy   (entry_busy),
    .entry_vacate (entry_vacate),
    .drained      (drained)
  );

  txq_pend u_pend (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_wr         (cfg_wr),
    .cfg_mode       (cfg_mode),
    .entry_vacate   (entry_vacate),
    .drained        (drained),
    .eof_evt        (eof_evt),
    .host_wr        (host_wr),
    .clr_pend       (clr_pend),
    .pend           (pend),
    .mode_all_empty (mode_all_empty)
  );

  always_comb ovf_d = ovf_q | (host_wr & entry_busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign overflow  = ovf_q;
  assign buf_empty = ~entry_busy;
  assign irq       = pend & irq_en;
endmodule

// File: rtl/txfifo_irq_ctrl_chk.sv
module txfifo_irq_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_wr,
  input logic          clr_pend,
  input logic          eof_evt,
  input logic          irq_en,
  input logic          ld_req,
  input logic          ld_ack,
  input logic [DW-1:0] ld_data,
  input logic          buf_empty,
  input logic          pend,
  input logic          irq,
  input logic          overflow,
  input logic          mode_all_empty
);
  // R2: head byte is held until taken
  a_r2_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && !ld_ack) |=> (ld_req && $stable(ld_data)));

  // R3: colliding write marks overflow, which then sticks
  a_r3_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !buf_empty) |=> overflow);
  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R4: accepted write fills the entry slot
  a_r4_entry_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && buf_empty) |=> !buf_empty);

  // R6: per-slot policy raises pend when the entry slot frees
  a_r6_vacate_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(buf_empty) && !$past(mode_all_empty)) |-> pend);

  // R7: accepted write with no end-of-frame clears pend
  a_r7_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && buf_empty && !eof_evt) |=> !pend);

  // R8 / R9: end-of-frame wins over any clear
  a_r9_eof_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_evt && (clr_pend || host_wr || !clr_pend)) |=> pend);

  // R10: line is never active without enable
  a_r10_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);
endmodule

bind txfifo_irq_ctrl txfifo_irq_ctrl_chk #(.DW(DW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .host_wr        (host_wr),
  .clr_pend       (clr_pend),
  .eof_evt        (eof_evt),
  .irq_en         (irq_en),
  .ld_req         (ld_req),
  .ld_ack         (ld_ack),
  .ld_data        (ld_data),
  .buf_empty      (buf_empty),
  .pend           (pend),
  .irq            (irq),
  .overflow       (overflow),
  .mode_all_empty (mode_all_empty)
);

// File: tb/txfifo_irq_ctrl_tb.sv
module txfifo_irq_ctrl_tb;
  localparam int DW = 8;

  logic          clk, rst_n;
  logic          host_wr, cfg_wr, cfg_mode, irq_en, clr_pend, ld_ack, eof_evt;
  logic [DW-1:0] host_data;
  logic          ld_req, buf_empty, pend, irq, overflow;
  logic [DW-1:0] ld_data;

  int n_chk = 0;
  int n_bad = 0;

  txfifo_irq_ctrl #(.DEPTH(4), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_data(host_data),
    .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .irq_en(irq_en), .clr_pend(clr_pend),
    .ld_req(ld_req), .ld_data(ld_data), .ld_ack(ld_ack), .eof_evt(eof_evt),
    .buf_empty(buf_empty), .pend(pend), .irq(irq), .overflow(overflow)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // row: {wr, data, ack, exp_buf_empty, exp_pend, exp_ld_req, exp_ld_data}
  localparam int NV = 12;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 8'hA1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00},
    {1'b1, 8'hA2, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 8'hA1},
    {1'b1, 8'hA3, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA1},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 8'hA1},
    {1'b1, 8'hA4, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA1},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA1},
    {1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA1},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 8'hA2},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA2},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 8'hA2}
  };

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    host_wr = 0; cfg_wr = 0; clr_pend = 0; ld_ack = 0; eof_evt = 0;
  endtask

  task automatic wr_byte(input logic [DW-1:0] d);
    while (!buf_empty) @(negedge clk);
    host_wr = 1; host_data = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic pop_chk(input logic [DW-1:0] d, input string tag);
    while (!ld_req) @(negedge clk);
    chk(tag, ld_data, d);
    ld_ack = 1;
    @(negedge clk);
    ld_ack = 0;
  endtask

  task automatic pulse_clr();
    clr_pend = 1;
    @(negedge clk);
    clr_pend = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    idle(); irq_en = 0; cfg_mode = 1; host_data = '0;
    do_reset();

    // R1 reset state
    chk("R1 buf_empty", buf_empty, 1);
    chk("R1 pend", pend, 0);
    chk("R1 irq", irq, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 ld_req", ld_req, 0);

    // R10 enabling alone does not set pend
    irq_en = 1;
    repeat (3) @(negedge clk);
    chk("R10 enable no pend", pend, 0);
    irq_en = 0;

    // R5 / R2 / R4: default drain-empty policy, single byte
    host_wr = 1; host_data = 8'hB1;
    @(negedge clk); host_wr = 0;
    chk("R4 filled", buf_empty, 0);
    @(negedge clk);
    chk("R4 entry freed", buf_empty, 1);
    chk("R5 no set on vacate (R1 default policy)", pend, 0);
    @(negedge clk);
    chk("R2 not yet at exit", ld_req, 0);
    @(negedge clk);
    chk("R2 at exit", ld_req, 1);
    chk("R2 data", ld_data, 8'hB1);
    ld_ack = 1;
    @(negedge clk); ld_ack = 0;
    chk("R5 drained sets", pend, 1);
    chk("R10 gated off", irq, 0);
    irq_en = 1; #1;
    chk("R10 gated on", irq, 1);
    @(negedge clk);
    pulse_clr();
    chk("R7 clr_pend clears", pend, 0);
    chk("R10 irq drops", irq, 0);

    // R5 two bytes: only the last pop sets
    wr_byte(8'hD1);
    wr_byte(8'hD2);
    pop_chk(8'hD1, "R2 order D1");
    chk("R5 not empty yet", pend, 0);
    pop_chk(8'hD2, "R2 order D2");
    chk("R5 last pop sets", pend, 1);

    // R11 switch to per-slot policy, clear pend together
    cfg_wr = 1; cfg_mode = 0; clr_pend = 1;
    @(negedge clk);
    idle();

    // table walk: R6, R7, R4, R2, R3
    for (int k = 0; k < NV; k++) begin
      host_wr = VEC[k][20]; host_data = VEC[k][19:12]; ld_ack = VEC[k][11];
      @(negedge clk);
      idle();
      chk($sformatf("R4 row%0d buf_empty", k), buf_empty, VEC[k][10]);
      chk($sformatf("R6/R7 row%0d pend", k), pend, VEC[k][9]);
      chk($sformatf("R2 row%0d ld_req", k), ld_req, VEC[k][8]);
      if (VEC[k][8]) chk($sformatf("R2 row%0d ld_data", k), ld_data, VEC[k][7:0]);
    end
    chk("R3 overflow set", overflow, 1);
    pop_chk(8'hA2, "R2 drain A2");
    pop_chk(8'hA3, "R2 drain A3");
    pop_chk(8'hA4, "R3 dropped byte absent A4");
    chk("R3 nothing after A4", ld_req, 0);
    chk("R3 overflow sticky", overflow, 1);

    // R8 vacate set beats clear
    pulse_clr();
    host_wr = 1; host_data = 8'hC1;
    @(negedge clk);
    host_wr = 0; clr_pend = 1;
    @(negedge clk);
    clr_pend = 0;
    chk("R8 vacate beats clr", pend, 1);
    pop_chk(8'hC1, "R2 C1");

    // R9 end-of-frame
    pulse_clr();
    chk("R7 cleared before eof", pend, 0);
    eof_evt = 1;
    @(negedge clk); eof_evt = 0;
    chk("R9 eof sets", pend, 1);
    chk("R9 buf_empty at eof", buf_empty, 1);
    eof_evt = 1; clr_pend = 1;
    @(negedge clk); idle();
    chk("R8 eof beats clr", pend, 1);

    // R1 reset restores drain-empty policy
    do_reset();
    chk("R1 overflow cleared", overflow, 0);
    wr_byte(8'hE1);
    @(negedge clk);
    chk("R1 policy back to drain-empty", pend, 0);
    pop_chk(8'hE1, "R2 E1");
    chk("R5 after reset", pend, 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule